// File: doc/BRIEF.md
# Wake-Up Event Enable and Status Controller

This block gathers four wake-up request lines that arrive asynchronously: a serial ring-indicator line, a single-pulse network wake notice, an external power button and a real-time-clock alarm. Each line passes through its own synchroniser. The rising edge of the synchronised level counts as an event. Every event is recorded in a sticky status bit, whether or not its source is enabled.

A single power-on request output stays high while a recorded event belongs to an enabled source. Software reaches two registers through a small read/write port. The enable register is read/write. The status register is read back, and software clears a status bit by writing a 1 to it. The ring-indicator line gets no debounce: every synchronised rising edge counts.

Top module: `wake_ctrl`

## Requirements
- R1: Source bit positions in both registers are: ring indicator bit 0, network wake bit 1, power button bit 2, RTC alarm bit 3. An event is a rising edge of the synchronised input. It shows in the status register SYNC_STAGES+1 clock edges after the input rises.
- R2: A status bit is set on its event whether its enable bit is 0 or 1. Only an event can set a status bit.
- R3: pwr_req_o is high exactly while some bit is 1 in both status and enable, and low otherwise.
- R4: Address 0 is the enable register. A write loads all four bits from reg_wdata_i, and reg_rdata_o returns the value combinationally. Without a write to address 0 the enable register holds its value.
- R5: Address 1 reads the status register. Writing 1 to a bit position clears that status bit. Writing 0 leaves it unchanged.
- R6: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: An input held high produces only one event. A falling edge produces none, so a cleared bit stays clear while its input remains high.
- R8: The ring-indicator input is not debounced. A high level lasting one clock period is enough to record an event.
- R9: After reset the enable and status registers are zero and pwr_req_o is low.
- R10: Addresses 2 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_i | input | 1 | Serial ring-indicator wake line, active high, asynchronous |
| net_wake_i | input | 1 | Network wake notice pulse, active high, asynchronous |
| button_i | input | 1 | External power button, active high, asynchronous |
| rtc_alarm_i | input | 1 | Real-time-clock alarm, active high, asynchronous |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 status |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 4 | Write data: the enable value, or a clear mask for status |
| reg_rdata_o | output | 4 | Read data of the addressed register |
| pwr_req_o | output | 1 | Power-on request |

## Verification
The bench builds the block with its default two-stage synchroniser, so the expected status update falls three edges after each input rise. The bench model derives that latency from the parameter. It can therefore time a clearing write to land on exactly the edge where an event is recorded. With all four sources present, random enable values and event masks reach every pairing of an enabled or disabled source with a set or clear status bit.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int NUM_SRC    = 4;
    localparam int SRC_RING   = 0;
    localparam int SRC_NET    = 1;
    localparam int SRC_BTN    = 2;
    localparam int SRC_RTC    = 3;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]                  prev;
    } sync_state_t;

    sync_state_t d, q;

    always_comb begin
        d          = q;
        d.chain[0] = async_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.prev = q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.chain[LAST];

    // Per-source edge detect from the synchronised level
    for (genvar k = 0; k < WIDTH; k++) begin : g_edge
        assign rise_o[k] = q.chain[LAST][k] & ~q.prev[k];
    end

    // R7: a rise lasts exactly one cycle, so a held level yields one event
    a_r7_single_cycle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  src_vec_t              ev_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic                  wr_i,
    input  src_vec_t              wdata_i,
    output src_vec_t              enable_o,
    output src_vec_t              status_o,
    output src_vec_t              rdata_o
);
    typedef struct packed {
        src_vec_t enable;
        src_vec_t status;
    } regs_t;

    regs_t    d, q;
    src_vec_t clr_mask;
    logic     en_wr;

    always_comb begin
        en_wr    = wr_i && (addr_i == ADDR_ENABLE);
        clr_mask = (wr_i && (addr_i == ADDR_STATUS)) ? wdata_i : '0;
        d        = q;
        if (en_wr) d.enable = wdata_i;
        // clear first, then events, so a same-cycle event survives
        d.status = (q.status & ~clr_mask) | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (addr_i)
            ADDR_ENABLE: rdata_o = q.enable;
            ADDR_STATUS: rdata_o = q.status;
            default:     rdata_o = '0;
        endcase
    end

    assign enable_o = q.enable;
    assign status_o = q.status;

    // R5: bits not cleared stay set
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.status & $past(q.status & ~clr_mask)) == $past(q.status & ~clr_mask)));
    // R6: an event always lands
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((q.status & $past(ev_i)) == $past(ev_i)));
    // R2: only an event raises a status bit
    a_r2_only_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.status & ~$past(q.status) & ~$past(ev_i)) == '0));
    // R4: enable holds without a write to its address
    a_r4_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(q.enable));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ring_i,
    input  logic                  net_wake_i,
    input  logic                  button_i,
    input  logic                  rtc_alarm_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [NUM_SRC-1:0]    reg_wdata_i,
    output logic [NUM_SRC-1:0]    reg_rdata_o,
    output logic                  pwr_req_o
);
    src_vec_t raw_src, sync_level, rise, enable, status;

    always_comb begin
        raw_src           = '0;
        raw_src[SRC_RING] = ring_i;
        raw_src[SRC_NET]  = net_wake_i;
        raw_src[SRC_BTN]  = button_i;
        raw_src[SRC_RTC]  = rtc_alarm_i;
    end

    wake_sync #(
        .WIDTH       (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_src),
        .level_o (sync_level),
        .rise_o  (rise)
    );

    wake_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (rise),
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .enable_o (enable),
        .status_o (status),
        .rdata_o  (reg_rdata_o)
    );

    assign pwr_req_o = |(status & enable);

    // R3: an event on an enabled source raises the request next cycle
    a_r3_enabled_event_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & enable)) |=> pwr_req_o);
    // R2: a disabled event still records status
    a_r2_disabled_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & ~enable)) |=> ((status & $past(rise & ~enable)) == $past(rise & ~enable)));

    logic unused_level;
    assign unused_level = ^sync_level;
endmodule

// File: tb/wake_ctrl_tb.sv
module wake_ctrl_tb_top;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = '0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       pwr_req;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_en = '0;
    logic [3:0] exp_st = '0;

    always #2.5 clk = ~clk;

    wake_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ring_i(src[0]), .net_wake_i(src[1]), .button_i(src[2]), .rtc_alarm_i(src[3]),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .pwr_req_o(pwr_req)
    );

    function automatic logic exp_req(logic [3:0] st, logic [3:0] en);
        return |(st & en);
    endfunction

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [3:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic check_all(string req);
        logic [3:0] v;
        rd(2'd0, v); chk({req, " enable"}, v, exp_en);
        rd(2'd1, v); chk({req, " status"}, v, exp_st);
        chk({req, " R3 pwr_req"}, {3'b0, pwr_req}, {3'b0, exp_req(exp_st, exp_en)});
    endtask

    task automatic wr_reg(logic [1:0] a, logic [3:0] v);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        if (a == 2'd0) exp_en = v;
        else if (a == 2'd1) exp_st = exp_st & ~v;
    endtask

    task automatic fire(logic [3:0] m);
        src = src | m;
        repeat (LAT) @(negedge clk);
        exp_st = exp_st | m;
        src = src & ~m;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset");

        // R2: disabled sources still record, one at a time
        for (int k = 0; k < 4; k++) begin
            fire(4'(1 << k));
            check_all("R1 R2 per-source");
        end
        // R4 enable write then R3 request
        wr_reg(2'd0, 4'b0100);
        check_all("R4 R3 enable");
        // R5 clear with a mixed mask
        wr_reg(2'd1, 4'b0101);
        check_all("R5 clear");
        wr_reg(2'd1, 4'b0000);
        check_all("R5 zero write");

        // R1 latency: not visible one edge early
        src[3] = 1'b1;
        repeat (LAT - 1) @(negedge clk);
        rd(2'd1, v); chk("R1 latency early", v, exp_st);
        @(negedge clk);
        exp_st[3] = 1'b1;
        rd(2'd1, v); chk("R1 latency on time", v, exp_st);
        // R7: held high, clear, stays clear
        wr_reg(2'd1, 4'b1000);
        repeat (LAT + 2) @(negedge clk);
        check_all("R7 held level");
        src[3] = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        check_all("R7 falling edge");

        // R6: event and clear in the same cycle
        fire(4'b0011);
        src[1] = 1'b1;
        repeat (LAT - 1) @(negedge clk);
        addr = 2'd1; wdata = 4'b0011; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        exp_st = (exp_st & ~4'b0011) | 4'b0010;
        check_all("R6 event wins");
        src[1] = 1'b0;
        repeat (LAT) @(negedge clk);

        // R8: one-cycle ring pulse
        wr_reg(2'd1, 4'b1111);
        wr_reg(2'd0, 4'b0001);
        src[0] = 1'b1;
        @(negedge clk);
        src[0] = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        exp_st[0] = 1'b1;
        check_all("R8 short ring pulse");

        // R10: unused addresses
        wr_reg(2'd2, 4'b1111);
        wr_reg(2'd3, 4'b1111);
        check_all("R10 ignored write");
        rd(2'd2, v); chk("R10 read addr2", v, 4'b0000);
        rd(2'd3, v); chk("R10 read addr3", v, 4'b0000);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            int op;
            op = $urandom % 3;
            case (op)
                0: wr_reg(2'd0, 4'($urandom));
                1: wr_reg(2'd1, 4'($urandom));
                default: fire(4'($urandom));
            endcase
            check_all("R2 R3 R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule